// File: doc/BRIEF.md
# Three-Stage Decimating FIR Chain with Shared Coefficient Store

This block runs a stream of signed 24-bit samples through three low-pass FIR filters in series. Each filter also decimates: it emits one output for every R samples it accepts. Each filter uses a single multiply-accumulate unit that walks its taps one per clock. All three filters read their coefficients from one shared store. Software loads the store through a two-step port: it writes a start address once, then writes coefficient words one after another, and the load pointer moves forward by one after each word.

The coefficient sets lie back to back in stage order. Each stage finds its first coefficient from the tap counts of the stages ahead of it, so reprogramming one tap count moves the regions of the later stages with it. Each stage has an 18-bit control word that sets its tap count, its decimation ratio and how the wide accumulator is brought back to 24 bits.

When the enable is high, the filters run and the store is locked against writes. When the enable is low, every stage is cleared.

Top module: `fir_chain`

## Requirements
- R1: A write on the address strobe sets the load pointer. Each data strobe then stores `coef_data` at the pointer and advances the pointer by one. If both strobes are high in the same cycle, the address write wins and that cycle's data word is dropped.
- R2: While `flt_en` is 1, the address strobe and the data strobe have no effect. The pointer and the stored coefficients keep their values.
- R3: Stage 1 reads its coefficients starting at address 0. Stage 2 starts at the stage 1 tap count, and stage 3 starts at the sum of the stage 1 and stage 2 tap counts.
- R4: The control word fields are: tap count in bits [8:0], decimation ratio in bits [15:12], rounding mode in bits [17:16]. Bits [11:9] are ignored. A ratio of 0 behaves as a ratio of 1.
- R5: A stage with T taps and ratio R produces one output after every R-th accepted sample, equal to the sum over i<T of c[base+i]·x[n−i]. Here x[n] is the newest accepted sample, and history from before the last enable counts as zero.
- R6: The accumulator is divided by 2^23 with an arithmetic shift. Mode 0 truncates toward minus infinity. Any other mode first adds 2^22, which rounds half up. The result saturates to the range −8388608..8388607.
- R7: A stage with a tap count of 0 outputs 0 whenever its ratio is reached.
- R8: For a sample that completes a decimation in all three stages, `out_valid` rises T1+T2+T3+5 clock edges after the edge that captures that sample.
- R9: A stage accepts a sample only while it is not computing. A sample that arrives during a computation is dropped and is not stored in the history.
- R10: After reset, `out_valid` and `out_data` are 0. One cycle after `flt_en` is sampled low, both are 0 and all history and phase are cleared. `out_valid` is a one-cycle pulse, and `out_data` holds its value between pulses.
- R11: The package default control words give a ratio of 2 for every stage, rounding mode 1 for stages 1 and 3, and mode 0 for stage 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flt_en | input | 1 | Runs the filters and locks the coefficient store |
| ctl_s1 | input | 18 | Stage 1 control word |
| ctl_s2 | input | 18 | Stage 2 control word |
| ctl_s3 | input | 18 | Stage 3 control word |
| coef_addr_wr | input | 1 | Load pointer write strobe |
| coef_addr | input | 9 | New load pointer value |
| coef_data_wr | input | 1 | Coefficient write strobe |
| coef_data | input | 24 | Signed coefficient |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 24 | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 24 | Signed output sample |

## Verification
A stage with T taps makes its result T+1 edges after it captures a sample. Each hop between stages adds one more edge, so a chain output is due T1+T2+T3+5 edges after the input edge that completed it. The bench counts clock edges and stamps every input with the edge that captures it. A negative-edge monitor records each output with its edge count. Every output is then compared against the reference model in both value and arrival edge. Inputs are spaced farther apart than the full chain latency, except in the one test that deliberately sends a sample into a busy stage.

// File: rtl/fir_pkg.sv
package fir_pkg;

    localparam int NST    = 3;
    localparam int CTL_W  = 18;

    typedef struct packed {
        logic [1:0] rnd;
        logic [3:0] ratio;
        logic [8:0] taps;
    } stage_cfg_t;

    function automatic stage_cfg_t ctl_fields(input logic [CTL_W-1:0] w);
        stage_cfg_t c;
        c.taps  = w[8:0];
        c.ratio = w[15:12];
        c.rnd   = w[17:16];
        return c;
    endfunction

    // Power-on defaults: ratio 2 everywhere, round/trunc/round, taps filled in later
    localparam logic [CTL_W-1:0] CTL_DEF_S1 = {2'd1, 4'd2, 3'd0, 9'd0};
    localparam logic [CTL_W-1:0] CTL_DEF_S2 = {2'd0, 4'd2, 3'd0, 9'd0};
    localparam logic [CTL_W-1:0] CTL_DEF_S3 = {2'd1, 4'd2, 3'd0, 9'd0};

endpackage

// File: rtl/fir_coef_mem.sv
module fir_coef_mem #(
    parameter int DEPTH = 336,
    parameter int AW    = 9,
    parameter int CW    = 24,
    parameter int NRD   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lock,
    input  logic                     addr_wr,
    input  logic [AW-1:0]            addr_in,
    input  logic                     data_wr,
    input  logic [CW-1:0]            data_in,
    input  logic [NRD-1:0][AW-1:0]   rd_addr,
    output logic [NRD-1:0][CW-1:0]   rd_data
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH);

    logic [AW-1:0] ptr_d, ptr_q;
    logic          we;
    logic [CW-1:0] mem_q [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        we    = 1'b0;
        if (!lock) begin
            if (addr_wr) begin
                ptr_d = addr_in;
            end else if (data_wr && (ptr_q < LAST)) begin
                we    = 1'b1;
                ptr_d = ptr_q + AW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            ptr_q <= ptr_d;
            if (we) mem_q[ptr_q] <= data_in;
        end
    end

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        assign rd_data[k] = (rd_addr[k] < LAST) ? mem_q[rd_addr[k]] : '0;
    end

endmodule

// File: rtl/fir_dec_stage.sv
module fir_dec_stage
    import fir_pkg::*;
#(
    parameter int SW       = 24,
    parameter int CW       = 24,
    parameter int AW       = 9,
    parameter int MAX_TAPS = 64,
    parameter int FRAC     = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  stage_cfg_t           cfg,
    input  logic [AW-1:0]        base,
    input  logic                 in_vld,
    input  logic signed [SW-1:0] in_smp,
    output logic [AW-1:0]        coef_addr,
    input  logic [CW-1:0]        coef_val,
    output logic                 out_vld,
    output logic signed [SW-1:0] out_smp
);

    localparam int HW    = $clog2(MAX_TAPS);
    localparam int CNT_W = HW + 1;
    localparam int ACC_W = SW + CW + HW + 1;
    localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(2 ** (SW - 1) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

    typedef struct packed {
        logic                    busy;
        logic [HW-1:0]           wp;
        logic [HW-1:0]           newest;
        logic [3:0]              phase;
        logic [CNT_W-1:0]        idx;
        logic signed [ACC_W-1:0] acc;
        logic                    ovld;
        logic signed [SW-1:0]    osmp;
    } st_t;

    st_t st_d, st_q;

    logic signed [SW-1:0] hist_q [MAX_TAPS];
    logic                 h_we;
    logic [HW-1:0]        rd_idx;
    logic [CNT_W-1:0]     taps_eff;
    logic [3:0]           rat_m1;
    logic signed [SW+CW-1:0] prod;

    function automatic logic signed [SW-1:0] scale_sat(input logic signed [ACC_W-1:0] a,
                                                       input logic up);
        logic signed [ACC_W-1:0] s;
        s = (up ? a + HALF : a) >>> FRAC;
        if (s > SAT_HI) return SAT_HI[SW-1:0];
        if (s < SAT_LO) return SAT_LO[SW-1:0];
        return s[SW-1:0];
    endfunction

    assign taps_eff  = (cfg.taps > 9'(MAX_TAPS)) ? CNT_W'(MAX_TAPS) : CNT_W'(cfg.taps);
    assign rat_m1    = (cfg.ratio == 4'd0) ? 4'd0 : cfg.ratio - 4'd1;
    assign rd_idx    = st_q.newest - st_q.idx[HW-1:0];
    assign coef_addr = base + AW'(st_q.idx);
    assign prod      = $signed(coef_val) * hist_q[rd_idx];

    always_comb begin
        st_d      = st_q;
        st_d.ovld = 1'b0;
        h_we      = 1'b0;
        if (!en) begin
            st_d = '0;
        end else if (!st_q.busy) begin
            if (in_vld) begin
                h_we        = 1'b1;
                st_d.wp     = st_q.wp + HW'(1);
                st_d.newest = st_q.wp;
                if (st_q.phase >= rat_m1) begin
                    st_d.phase = 4'd0;
                    st_d.busy  = 1'b1;
                    st_d.idx   = '0;
                    st_d.acc   = '0;
                end else begin
                    st_d.phase = st_q.phase + 4'd1;
                end
            end
        end else if (st_q.idx == taps_eff) begin
            st_d.busy = 1'b0;
            st_d.ovld = 1'b1;
            st_d.osmp = scale_sat(st_q.acc, cfg.rnd != 2'd0);
        end else begin
            st_d.acc = st_q.acc + ACC_W'(prod);
            st_d.idx = st_q.idx + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_TAPS; i++) hist_q[i] <= '0;
        end else if (!en) begin
            for (int i = 0; i < MAX_TAPS; i++) hist_q[i] <= '0;
        end else if (h_we) begin
            hist_q[st_q.wp] <= in_smp;
        end
    end

    assign out_vld = st_q.ovld;
    assign out_smp = st_q.osmp;

endmodule

// File: rtl/fir_chain.sv
module fir_chain
    import fir_pkg::*;
#(
    parameter int SMP_W     = 24,
    parameter int COEF_W    = 24,
    parameter int MEM_DEPTH = 336,
    parameter int MAX_TAPS  = 64,
    parameter int FRAC      = 23,
    localparam int AW       = $clog2(MEM_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_en,
    input  logic [CTL_W-1:0]  ctl_s1,
    input  logic [CTL_W-1:0]  ctl_s2,
    input  logic [CTL_W-1:0]  ctl_s3,
    input  logic              coef_addr_wr,
    input  logic [AW-1:0]     coef_addr,
    input  logic              coef_data_wr,
    input  logic [COEF_W-1:0] coef_data,
    input  logic              in_valid,
    input  logic [SMP_W-1:0]  in_data,
    output logic              out_valid,
    output logic [SMP_W-1:0]  out_data
);

    stage_cfg_t                  cfg_w [NST];
    logic [NST-1:0][AW-1:0]      base_w;
    logic [NST-1:0][AW-1:0]      rd_addr;
    logic [NST-1:0][COEF_W-1:0]  rd_data;
    logic [NST:0]                vld_c;
    logic [NST:0][SMP_W-1:0]     smp_c;
    logic                        unused_ctl_bits;

    assign cfg_w[0] = ctl_fields(ctl_s1);
    assign cfg_w[1] = ctl_fields(ctl_s2);
    assign cfg_w[2] = ctl_fields(ctl_s3);
    assign unused_ctl_bits = ^{ctl_s1[11:9], ctl_s2[11:9], ctl_s3[11:9]};

    // Regions are packed back to back: each base is the running tap sum
    assign base_w[0] = '0;
    for (genvar g = 1; g < NST; g++) begin : g_base
        assign base_w[g] = base_w[g-1] + AW'(cfg_w[g-1].taps);
    end

    fir_coef_mem #(
        .DEPTH (MEM_DEPTH),
        .AW    (AW),
        .CW    (COEF_W),
        .NRD   (NST)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock    (flt_en),
        .addr_wr (coef_addr_wr),
        .addr_in (coef_addr),
        .data_wr (coef_data_wr),
        .data_in (coef_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign vld_c[0] = in_valid;
    assign smp_c[0] = in_data;

    for (genvar g = 0; g < NST; g++) begin : g_stage
        fir_dec_stage #(
            .SW       (SMP_W),
            .CW       (COEF_W),
            .AW       (AW),
            .MAX_TAPS (MAX_TAPS),
            .FRAC     (FRAC)
        ) u_stg (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (flt_en),
            .cfg       (cfg_w[g]),
            .base      (base_w[g]),
            .in_vld    (vld_c[g]),
            .in_smp    (smp_c[g]),
            .coef_addr (rd_addr[g]),
            .coef_val  (rd_data[g]),
            .out_vld   (vld_c[g+1]),
            .out_smp   (smp_c[g+1])
        );
    end

    assign out_valid = vld_c[NST];
    assign out_data  = smp_c[NST];

endmodule

// File: rtl/fir_chain_chk.sv
module fir_chain_chk #(
    parameter int SW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flt_en,
    input logic          in_valid,
    input logic          out_valid,
    input logic [SW-1:0] out_data
);

    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               seen_q <= 1'b0;
        else if (!flt_en)         seen_q <= 1'b0;
        else if (in_valid)        seen_q <= 1'b1;
    end

    // R10: outputs are single-cycle pulses
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R10: disabling clears the output on the next edge
    p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_en |=> (!out_valid && out_data == '0));

    // R10: data holds between pulses while running
    p_data_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flt_en) && !out_valid) |-> $stable(out_data));

    // R5: no output before a sample has been taken since enable
    p_out_needs_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> seen_q);

endmodule

bind fir_chain fir_chain_chk #(.SW(SMP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flt_en    (flt_en),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sim_fir_chain.sv
`timescale 1ns/1ps
module sim_fir_chain;
    import fir_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flt_en = 1'b0;
    logic [17:0] ctl_s1 = '0, ctl_s2 = '0, ctl_s3 = '0;
    logic        coef_addr_wr = 1'b0;
    logic [8:0]  coef_addr = '0;
    logic        coef_data_wr = 1'b0;
    logic [23:0] coef_data = '0;
    logic        in_valid = 1'b0;
    logic [23:0] in_data = '0;
    logic        out_valid;
    logic [23:0] out_data;

    fir_chain u0 (.*);

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // columns: t1 t2 t3 r1 r2 r3 m1 m2 m3 pattern n_inputs expected_outputs
    localparam int NCFG = 6;
    localparam int CFG [NCFG][12] = '{
        '{ 8,  6,  5, 2, 2, 2, 1, 0, 1, 0, 32, 4},
        '{ 3,  4,  2, 1, 1, 1, 0, 0, 0, 1, 12, 12},
        '{ 5,  3,  7, 3, 1, 2, 1, 1, 1, 2, 24, 4},
        '{ 4,  1,  1, 1, 1, 1, 0, 0, 0, 3,  6, 6},
        '{ 2,  2,  2, 0, 0, 0, 1, 1, 1, 1,  8, 8},
        '{16, 16, 16, 2, 1, 2, 2, 3, 0, 2, 20, 5}
    };

    // reference model state
    int cm [336];
    int pm = 0;
    int hm [3][64];
    int wpm [3];
    int phm [3];
    int tk [3], rk [3], mk [3];
    int exp_v[$], exp_t[$], got_v[$], got_t[$];

    always @(negedge clk) if (out_valid) begin
        got_v.push_back(int'($signed(out_data)));
        got_t.push_back(cyc);
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int scale_ref(input longint acc, input int m);
        longint b;
        b = (m != 0) ? acc + 64'sd4194304 : acc;
        b = b >>> 23;
        if (b > 8388607) return 8388607;
        if (b < -8388608) return -8388608;
        return int'(b);
    endfunction

    function automatic int coef_gen(input int pat, input int i);
        case (pat)
            0: return ((i * 97 + 13) % 512 - 256) * 8192;
            1: return ((i * 31 + 7) % 64 - 32) * 65536;
            2: return ((i % 2) ? -1 : 1) * ((i + 3) * 32768);
            default: return 8388607;
        endcase
    endfunction

    function automatic int in_gen(input int pat, input int n);
        if (pat == 3) return 8388607;
        return ((n * 1237 + pat * 511) % 4001 - 2000) * 3001;
    endfunction

    task automatic model_clear();
        for (int s = 0; s < 3; s++) begin
            wpm[s] = 0; phm[s] = 0;
            for (int i = 0; i < 64; i++) hm[s][i] = 0;
        end
    endtask

    task automatic model_feed(input int x, input int t_in);
        int v, base, nw, r;
        longint acc;
        v = x; base = 0;
        for (int s = 0; s < 3; s++) begin
            r = (rk[s] == 0) ? 1 : rk[s];
            hm[s][wpm[s]] = v; nw = wpm[s]; wpm[s] = (wpm[s] + 1) % 64;
            if (phm[s] < r - 1) begin
                phm[s]++;
                return;
            end
            phm[s] = 0;
            acc = 0;
            for (int i = 0; i < tk[s]; i++)
                acc += longint'(cm[base + i]) * longint'(hm[s][(nw - i + 64) % 64]);
            v = scale_ref(acc, mk[s]);
            base += tk[s];
        end
        exp_v.push_back(v);
        exp_t.push_back(t_in + tk[0] + tk[1] + tk[2] + 5);
    endtask

    task automatic wr_addr(input int a);
        @(negedge clk); coef_addr_wr = 1; coef_addr = 9'(a);
        @(negedge clk); coef_addr_wr = 0;
        if (!flt_en) pm = a;
    endtask

    task automatic wr_data(input int v);
        @(negedge clk); coef_data_wr = 1; coef_data = 24'(v);
        @(negedge clk); coef_data_wr = 0;
        if (!flt_en && pm < 336) begin cm[pm] = v; pm++; end
    endtask

    task automatic set_en(input bit e);
        @(negedge clk); flt_en = e;
        if (!e) begin @(negedge clk); model_clear(); end
    endtask

    function automatic logic [17:0] mk_ctl(input int t, input int r, input int m);
        return {2'(m), 4'(r), 3'b101, 9'(t)};
    endfunction

    task automatic set_cfg(input int t1, input int t2, input int t3,
                           input int r1, input int r2, input int r3,
                           input int m1, input int m2, input int m3);
        tk = '{t1, t2, t3}; rk = '{r1, r2, r3}; mk = '{m1, m2, m3};
        ctl_s1 = mk_ctl(t1, r1, m1); ctl_s2 = mk_ctl(t2, r2, m2); ctl_s3 = mk_ctl(t3, r3, m3);
    endtask

    task automatic feed(input int x, input int gap);
        int t_in;
        @(negedge clk); in_valid = 1; in_data = 24'(x); t_in = cyc + 1;
        @(negedge clk); in_valid = 0;
        model_feed(x, t_in);
        repeat (gap) @(negedge clk);
    endtask

    task automatic compare(input string req, input int want_cnt);
        chk(got_v.size() == exp_v.size(), {req, " output count vs model"}, got_v.size(), exp_v.size());
        if (want_cnt >= 0)
            chk(got_v.size() == want_cnt, "R4 R5 decimated output count", got_v.size(), want_cnt);
        for (int i = 0; i < exp_v.size() && i < got_v.size(); i++) begin
            chk(got_v[i] == exp_v[i], {req, " R6 value"}, got_v[i], exp_v[i]);
            chk(got_t[i] == exp_t[i], "R8 arrival edge", got_t[i], exp_t[i]);
        end
        exp_v.delete(); exp_t.delete(); got_v.delete(); got_t.delete();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int gap, tot;
        for (int i = 0; i < 336; i++) cm[i] = 0;
        model_clear();
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(out_valid == 0, "R10 reset valid", out_valid, 0);
        chk(out_data == 0, "R10 reset data", out_data, 0);

        // table walk: R3/R5 packing and filtering, R11 defaults on entry 0
        for (int c = 0; c < NCFG; c++) begin
            set_en(0);
            set_cfg(CFG[c][0], CFG[c][1], CFG[c][2], CFG[c][3], CFG[c][4], CFG[c][5],
                    CFG[c][6], CFG[c][7], CFG[c][8]);
            if (c == 0) begin
                ctl_s1 = CTL_DEF_S1 | 18'(CFG[c][0]);
                ctl_s2 = CTL_DEF_S2 | 18'(CFG[c][1]);
                ctl_s3 = CTL_DEF_S3 | 18'(CFG[c][2]);
            end
            tot = CFG[c][0] + CFG[c][1] + CFG[c][2];
            wr_addr(0);
            for (int i = 0; i < tot; i++) wr_data(coef_gen(CFG[c][9], i));
            set_en(1);
            gap = tot + 8;
            for (int n = 0; n < CFG[c][10]; n++) feed(in_gen(CFG[c][9], n), gap);
            compare(c == 0 ? "R11 R3 R5" : "R3 R5", CFG[c][11]);
        end

        // R2: writes while enabled are dropped, pointer untouched
        set_en(0);
        set_cfg(1, 1, 1, 1, 1, 1, 0, 0, 0);
        wr_addr(0);
        set_en(1);
        wr_data(123456); wr_data(-654321); wr_addr(50); wr_data(777);
        set_en(0);
        wr_data(4194304); wr_data(8388607); wr_data(-4194304);
        set_en(1);
        feed(1000000, 12);
        feed(-3000001, 12);
        compare("R2", 2);

        // R1: address and data strobes together, address wins
        set_en(0);
        set_cfg(2, 1, 1, 1, 1, 1, 0, 1, 0);
        wr_addr(0);
        @(negedge clk); coef_addr_wr = 1; coef_addr = 9'd1; coef_data_wr = 1; coef_data = 24'(999999);
        @(negedge clk); coef_addr_wr = 0; coef_data_wr = 0; pm = 1;
        wr_data(-2097152); wr_data(3145728); wr_data(6291456);
        set_en(1);
        feed(2500000, 12);
        feed(-1234567, 12);
        compare("R1", 2);

        // R7 with R3: stage 1 has zero taps, stage 2 region starts at 0
        set_en(0);
        set_cfg(0, 1, 1, 1, 1, 1, 1, 1, 1);
        set_en(1);
        for (int n = 0; n < 3; n++) feed(in_gen(1, n), 10);
        for (int i = 0; i < got_v.size(); i++) chk(got_v[i] == 0, "R7 zero-tap output", got_v[i], 0);
        compare("R7", 3);

        // R9: second sample arrives while stage 1 computes and is dropped
        set_en(0);
        set_cfg(4, 1, 1, 1, 1, 1, 0, 0, 0);
        wr_addr(0);
        wr_data(2097152); wr_data(4194304); wr_data(-1048576); wr_data(524288);
        wr_data(8388607); wr_data(8388607);
        set_en(1);
        begin
            int t_in;
            @(negedge clk); in_valid = 1; in_data = 24'(3000000); t_in = cyc + 1;
            @(negedge clk); in_data = 24'(-5000000);
            @(negedge clk); in_valid = 0;
            model_feed(3000000, t_in);
        end
        repeat (16) @(negedge clk);
        feed(1500000, 16);
        compare("R9", 2);

        // R10: disable clears outputs and history
        set_cfg(3, 1, 1, 1, 1, 1, 1, 0, 0);
        set_en(0);
        wr_addr(0);
        wr_data(4194304); wr_data(2097152); wr_data(1048576); wr_data(8388607); wr_data(8388607);
        set_en(1);
        feed(4000000, 14);
        feed(-2000000, 14);
        @(negedge clk); flt_en = 0;
        @(negedge clk);
        chk(out_valid == 0, "R10 disable valid", out_valid, 0);
        chk(out_data == 0, "R10 disable data", out_data, 0);
        model_clear();
        @(negedge clk); flt_en = 1;
        feed(1000000, 14);
        compare("R10", 3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule